// File: doc/BRIEF.md
# Eight-Channel Majority-Vote Input Filter

This block cleans up eight noisy binary levels that come from industrial sensor comparators. Each bit of the raw input vector first passes through a two-flop synchronizer. Each channel then takes one sample on every pulse of a slow sampling strobe and keeps its five most recent samples in a shift window. A channel's filtered bit moves to a new level only when at least four of those five samples agree on that level. When neither level has four votes, the bit keeps its last value. The eight channels share the clock, the reset and the strobe. They share no other state.

Each channel's filtered level is held by a two-state machine. In state `VF_LOW` the bit reads 0. The transition `T_RISE` to `VF_HIGH` is taken on a strobe cycle when the updated window holds four or more ones. In state `VF_HIGH` the bit reads 1. The transition `T_FALL` back to `VF_LOW` is taken on a strobe cycle when the updated window holds four or more zeros. On every other cycle the machine stays in its current state (`T_STAY`).

The strobe is expected to come from a slow filter-clock oscillator, typically around 1 kHz. The block uses it as a one-cycle enable in the system clock domain.

Top module: `vote_filter_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every synchronizer stage, every sample window and every filtered bit is cleared to 0. `filt_state` reads 8'h00 after that edge.
- R2: The sample windows advance only at rising edges where `sample_stb` is high. Changes on `raw_lvl` while the strobe is low leave both the windows and `filt_state` unchanged.
- R3: Bit i of `filt_state` becomes 1 when four or five of channel i's last five samples are 1.
- R4: Bit i of `filt_state` becomes 0 when four or five of channel i's last five samples are 0.
- R5: When channel i's last five samples split 3/2 in either direction, bit i of `filt_state` keeps its previous value.
- R6: Channel i takes its samples only from `raw_lvl[i]` and drives only `filt_state[i]`. A pattern on one channel has no effect on any other channel.
- R7: `raw_lvl` reaches the sampler through two register stages. A level applied between edges is captured by a strobe at the third rising edge after it is applied, or at any later edge. A strobe at the first or second such edge still captures the previous level.
- R8: `filt_state` changes only at the rising edge where the strobe that completes the four-of-five condition is high. The new value is visible in the cycle right after that strobe pulse, and not before it.
- R9: `sample_stb` is a pulse one clock wide. It is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the block acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| raw_lvl | input | 8 | Raw comparator levels, one bit per channel, asynchronous to `clk` |
| sample_stb | input | 1 | One-cycle sampling pulse from the filter-clock oscillator |
| filt_state | output | 8 | Filtered level, one bit per channel |

## Verification
The checker assumes that `sample_stb` is never high on two consecutive cycles, and it asserts this as an input rule. The bench keeps to that rule by following every strobe pulse with at least one idle cycle. For the ordinary sampling scenarios, the bench also holds `raw_lvl` steady for three edges before a strobe, so that each sample is the level that was applied. Only the latency scenario breaks this rule on purpose. That scenario strobes every second cycle straight after a raw change, which shows the two-stage delay described in R7.

// File: rtl/vf_pkg.sv
package vf_pkg;
    typedef enum logic {
        VF_LOW  = 1'b0,
        VF_HIGH = 1'b1
    } vf_state_t;
endpackage

// File: rtl/vf_sync.sv
module vf_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) begin
                stg[k] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/vf_channel.sv
module vf_channel
    import vf_pkg::*;
#(
    parameter int WINDOW = 5,
    parameter int AGREE  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              smp,
    output logic [WINDOW-1:0] win,
    output logic              filt
);
    localparam int CW = $clog2(WINDOW + 1);

    vf_state_t       state_q;
    vf_state_t       state_d;
    logic [WINDOW-1:0] win_nxt;
    logic [CW-1:0]   ones;
    logic [CW-1:0]   zeros;

    // Window as it will be after this strobe; the vote looks at it so the
    // filtered bit moves at the same edge as the completing sample.
    always_comb begin
        win_nxt = {win[WINDOW-2:0], smp};
        ones    = '0;
        for (int k = 0; k < WINDOW; k++) begin
            ones = ones + CW'(win_nxt[k]);
        end
        zeros = CW'(WINDOW) - ones;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (stb) begin
            win <= win_nxt;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VF_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_RISE, T_FALL, otherwise T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VF_LOW:  if (stb && (ones  >= CW'(AGREE))) state_d = VF_HIGH;
            VF_HIGH: if (stb && (zeros >= CW'(AGREE))) state_d = VF_LOW;
            default: state_d = VF_LOW;
        endcase
    end

    // Output decode
    always_comb begin
        filt = (state_q == VF_HIGH);
    end
endmodule

// File: rtl/vote_filter_bank.sv
module vote_filter_bank #(
    parameter int CHANNELS    = 8,
    parameter int WINDOW      = 5,
    parameter int AGREE       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] raw_lvl,
    input  logic                sample_stb,
    output logic [CHANNELS-1:0] filt_state
);
    localparam int WIN_BITS = CHANNELS * WINDOW;

    logic [CHANNELS-1:0] lvl_sync;
    logic [WIN_BITS-1:0] win_flat;

    vf_sync #(
        .WIDTH  (CHANNELS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (lvl_sync)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
        logic [WINDOW-1:0] win_ch;

        vf_channel #(
            .WINDOW (WINDOW),
            .AGREE  (AGREE)
        ) u_chan (
            .clk  (clk),
            .rst  (rst),
            .stb  (sample_stb),
            .smp  (lvl_sync[ch]),
            .win  (win_ch),
            .filt (filt_state[ch])
        );

        assign win_flat[ch*WINDOW +: WINDOW] = win_ch;
    end
endmodule

// File: rtl/vote_filter_bank_chk.sv
module vote_filter_bank_chk #(
    parameter int CHANNELS = 8,
    parameter int WINDOW   = 5,
    parameter int AGREE    = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         sample_stb,
    input logic [CHANNELS-1:0]          filt_state,
    input logic [CHANNELS*WINDOW-1:0]   win_flat
);
    assert_stb_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (filt_state == '0) && (win_flat == '0));

    assert_no_sample_R2: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(win_flat));

    assert_change_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(filt_state));

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chk
        assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(filt_state[ch]) |->
                ($countones(win_flat[ch*WINDOW +: WINDOW]) >= AGREE));

        assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
            $fell(filt_state[ch]) |->
                ($countones(win_flat[ch*WINDOW +: WINDOW]) <= WINDOW - AGREE));

        assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            ($past(sample_stb)
             && ($countones(win_flat[ch*WINDOW +: WINDOW]) > WINDOW - AGREE)
             && ($countones(win_flat[ch*WINDOW +: WINDOW]) < AGREE))
            |-> $stable(filt_state[ch]));
    end
endmodule

bind vote_filter_bank vote_filter_bank_chk #(
    .CHANNELS (CHANNELS),
    .WINDOW   (WINDOW),
    .AGREE    (AGREE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .filt_state (filt_state),
    .win_flat   (win_flat)
);

// File: tb/vote_filter_bank_test.sv
module vote_filter_bank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] raw_lvl = 8'h00;
    logic       sample_stb = 1'b0;
    logic [7:0] filt_state;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench-side reference: last five samples and filtered level per channel
    logic [4:0] hist [8];
    logic [7:0] exp_filt;

    always #10 clk = ~clk;

    vote_filter_bank uut (
        .clk        (clk),
        .rst        (rst),
        .raw_lvl    (raw_lvl),
        .sample_stb (sample_stb),
        .filt_state (filt_state)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: filt_state=%02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 8; c++) hist[c] = 5'b0;
        exp_filt = 8'h00;
    endtask

    task automatic model_sample(input logic [7:0] v);
        for (int c = 0; c < 8; c++) begin
            int ones;
            hist[c] = {hist[c][3:0], v[c]};
            ones = $countones(hist[c]);
            if (ones >= 4) exp_filt[c] = 1'b1;
            else if (ones <= 1) exp_filt[c] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_stb = 1'b0;
        raw_lvl = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // Apply a level, let it settle through the synchronizer, strobe once.
    task automatic push(input logic [7:0] v, input string req);
        raw_lvl = v;
        repeat (3) @(negedge clk);
        check(filt_state, exp_filt, "R8");   // unchanged before the strobe edge
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        model_sample(v);
        check(filt_state, exp_filt, req);
    endtask

    task automatic t_reset();
        do_reset();
        check(filt_state, 8'h00, "R1");
    endtask

    task automatic t_rise();
        do_reset();
        push(8'hFF, "R5");
        push(8'hFF, "R5");
        push(8'hFF, "R5");
        check(filt_state, 8'h00, "R5");
        push(8'hFF, "R3");
        check(filt_state, 8'hFF, "R3");
    endtask

    task automatic t_fall();
        push(8'h00, "R3");
        push(8'h00, "R5");
        push(8'h00, "R5");
        check(filt_state, 8'hFF, "R5");
        push(8'h00, "R4");
        check(filt_state, 8'h00, "R4");
    endtask

    task automatic t_alternate();
        do_reset();
        for (int k = 0; k < 8; k++) push((k % 2 == 0) ? 8'hFF : 8'h00, "R5");
        check(filt_state, 8'h00, "R5");
    endtask

    task automatic t_independent();
        do_reset();
        for (int k = 0; k < 4; k++) push(8'hA5, "R6");
        check(filt_state, 8'hA5, "R6");
        push(8'h5A, "R6");
        push(8'h0F, "R6");
        push(8'h5A, "R6");
        push(8'h5A, "R6");
        push(8'h5A, "R6");
        check(filt_state, 8'h5A, "R6");
    endtask

    task automatic t_no_strobe();
        logic [7:0] held;
        do_reset();
        push(8'hFF, "R2");
        push(8'hFF, "R2");
        push(8'hFF, "R2");
        held = filt_state;
        for (int k = 0; k < 20; k++) begin
            raw_lvl = (k % 2 == 0) ? 8'h00 : 8'h3C;
            @(negedge clk);
            check(filt_state, held, "R2");
        end
        // Window must still hold three ones: one more 1 completes four.
        push(8'hFF, "R2");
        check(filt_state, 8'hFF, "R2");
    endtask

    task automatic t_sync_latency();
        do_reset();
        raw_lvl = 8'hFF;
        @(negedge clk);                 // first edge passes with no strobe
        for (int k = 0; k < 4; k++) begin
            sample_stb = 1'b1;          // strobes at edges 2, 4, 6, 8
            @(negedge clk);
            sample_stb = 1'b0;
            @(negedge clk);
        end
        check(filt_state, 8'h00, "R7"); // edge-2 sample still held the old 0
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        check(filt_state, 8'hFF, "R7");
    endtask

    initial begin
        model_clear();
        t_reset();
        t_rise();
        t_fall();
        t_alternate();
        t_independent();
        t_no_strobe();
        t_sync_latency();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule